// File: doc/BRIEF.md
# Quadrature to Up/Down Clock Converter

This block turns the two phase-shifted square waves of an incremental encoder into pulse trains that a plain up/down counter can consume. Each of the two phase inputs and the index-track input is synchronised to the system clock and debounced. The filtered phases are then decoded into active-low count pulses on two separate outputs: one for forward motion and one for reverse motion. A level output shows the direction of the most recent counted step. An index pulse marks the reference position, and it is issued only on particular phase edges so that it lines up with the count pulses.

A two-bit mode input sets the resolution. Counting every phase edge gives four counts per encoder cycle. Counting both edges of phase A gives two counts. Counting only the rising edge of phase A gives one count. A width input sets how long each output pulse stays low, in system clocks. When both phases change in the same filtered sample, the step is invalid. It produces no pulse and raises a sticky error flag, which a clear input resets.

Top module: `quad_clock_converter`

## Requirements
- R1: The mode input `modeSel` selects the resolution. When `modeSel[1]` is 0, the block runs in x2 mode and `modeSel[0]` has no effect. `modeSel = 2'b10` selects x1 and `modeSel = 2'b11` selects x4.
- R2: A counted step in the forward direction pulses `upClkN` low. A counted step in the reverse direction pulses `dnClkN` low. Forward is the sequence in which A leads B, with (A,B) going 00→10→11→01→00. Reverse is the opposite sequence.
- R3: x4 mode counts every single edge of A or B. x2 mode counts only the edges of A. x1 mode counts only the rising edges of A, and the level of B sets the direction: B low means forward, B high means reverse.
- R4: `dirUp` becomes 1 after a forward count and 0 after a reverse count. It changes on the same clock edge on which the count pulse starts. It holds its value between counts.
- R5: `idxClkN` pulses low only when the filtered index input is high and either of two edges occurs. The first is a rising edge of A while B is low. The second is a falling edge of B while A is high. No other edge produces an index pulse, and the mode has no effect on it.
- R6: Each input must show a new level on FILT_LEN consecutive synchronised samples (default 3) before the filter accepts it. A shorter excursion is ignored. An accepted change drives the pulse output low starting at clock edge FILT_LEN+3, where edge 1 is the first edge that samples the new level.
- R7: A pulse stays low for exactly `pulseWidth` clocks. A `pulseWidth` of 0 is treated as 1.
- R8: A new event can arrive on an output whose pulse is still low. In that case the output goes high for exactly one clock and then low again for a full `pulseWidth`. The event is not dropped.
- R9: A simultaneous change of filtered A and filtered B produces no up, down or index pulse and sets `errFlag`. `errFlag` stays set until `errClear` is high at a clock edge.
- R10: During reset and after it, all pulse outputs are high, `dirUp` is 1 and `errFlag` is 0. The filters load the input levels present during reset, so inputs that are held steady through reset release produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| inA | input | 1 | Encoder phase A, asynchronous |
| inB | input | 1 | Encoder phase B, asynchronous |
| inIdx | input | 1 | Encoder index track, asynchronous |
| modeSel | input | 2 | Resolution select (see R1) |
| pulseWidth | input | WIDTH_W | Output pulse length in clocks |
| errClear | input | 1 | Clears the sticky error flag |
| upClkN | output | 1 | Active-low forward count pulses |
| dnClkN | output | 1 | Active-low reverse count pulses |
| idxClkN | output | 1 | Active-low index pulses |
| dirUp | output | 1 | Direction of the last counted step |
| errFlag | output | 1 | Sticky invalid-transition flag |

## Verification
The bench walks the full forward and reverse cycle in every mode, including phase edges that x1 and x2 must ignore. A decoder that mixed up the mode bits would emit pulses on those edges or change `dirUp`.

Index pulses are tried on all four phase edges while the index input is high. A design with the wrong edge or the wrong level condition would produce index pulses on the rising edge of B or on the falling edge of A.

Directed cases cover the following:
- the exact latency and pulse length, where an off-by-one in the filter or the stretcher shows up as a shifted or shortened low window;
- a zero width;
- a glitch one sample shorter than the filter length, which a weak filter would pass on as a count;
- a second event inside a live pulse, where a naive stretcher would merge two counts into one;
- a simultaneous phase change, which must stay silent and set the error flag;
- reset with all inputs held high, which must not produce a spurious pulse.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  typedef enum logic [1:0] {
    MODE_X2_LO = 2'b00,
    MODE_X2_HI = 2'b01,
    MODE_X1    = 2'b10,
    MODE_X4    = 2'b11
  } qccMode_e;

  typedef struct packed {
    logic upStb;
    logic dnStb;
    logic idxStb;
    logic errSet;
  } qccStrobes_t;

endpackage

// File: rtl/qcc_filter.sv
module qcc_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic syncA;
  logic syncB;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= rawIn;
      syncB   <= rawIn;
      filtOut <= rawIn;
      runCnt  <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB != filtOut) begin
        if (runCnt == CNT_W'(FILT_LEN - 1)) begin
          filtOut <= syncB;
          runCnt  <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtOut) |-> (filtOut == $past(syncB))); // R6

endmodule

// File: rtl/qcc_ctrl.sv
module qcc_ctrl
  import qcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fA,
  input  logic        fB,
  input  logic        fIdx,
  input  logic [1:0]  modeSel,
  output qccStrobes_t strb
);
  logic prevA;
  logic prevB;
  logic aChg;
  logic bChg;
  logic both;
  logic cntA;
  logic cntB;
  logic fwdA;
  logic fwdB;
  qccMode_e mode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= fA;
      prevB <= fB;
    end else begin
      prevA <= fA;
      prevB <= fB;
    end
  end

  assign aChg = fA ^ prevA;
  assign bChg = fB ^ prevB;
  assign both = aChg & bChg;
  assign mode = qccMode_e'(modeSel);
  // Step direction for an edge of A or of B, judged on the new levels.
  assign fwdA = fA ^ fB;
  assign fwdB = ~(fA ^ fB);

  always_comb begin
    cntA = 1'b0;
    cntB = 1'b0;
    case (mode)
      MODE_X4: begin
        cntA = aChg & ~bChg;
        cntB = bChg & ~aChg;
      end
      MODE_X1: cntA = aChg & ~bChg & fA;
      default: cntA = aChg & ~bChg;
    endcase
  end

  always_comb begin
    strb.upStb  = (cntA & fwdA) | (cntB & fwdB);
    strb.dnStb  = (cntA & ~fwdA) | (cntB & ~fwdB);
    strb.idxStb = fIdx & ~both & ((aChg & fA & ~fB) | (bChg & ~fB & fA));
    strb.errSet = both;
  end

  AST_X2_IGNORES_B: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && bChg && !aChg) |-> !(strb.upStb || strb.dnStb)); // R3
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (fA != prevA && fB != prevB) |-> !(strb.upStb || strb.dnStb || strb.idxStb)); // R9
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.upStb, strb.dnStb})); // R2

endmodule

// File: rtl/qcc_datapath.sv
module qcc_datapath
  import qcc_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  qccStrobes_t        strb,
  input  logic [WIDTH_W-1:0] pulseWidth,
  input  logic               errClear,
  output logic               upClkN,
  output logic               dnClkN,
  output logic               idxClkN,
  output logic               dirUp,
  output logic               errFlag
);
  localparam int N_OUT = 3;

  logic [N_OUT-1:0]   stbVec;
  logic [N_OUT-1:0]   lowVec;
  logic [WIDTH_W-1:0] loadVal;

  assign stbVec  = {strb.idxStb, strb.dnStb, strb.upStb};
  assign loadVal = (pulseWidth == '0) ? WIDTH_W'(1) : pulseWidth;

  for (genvar g = 0; g < N_OUT; g++) begin : gStretch
    logic [WIDTH_W-1:0] holdCnt;
    logic               gapPend;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdCnt <= '0;
        gapPend <= 1'b0;
      end else if (stbVec[g]) begin
        if (holdCnt != '0) begin
          holdCnt <= '0;
          gapPend <= 1'b1;
        end else begin
          holdCnt <= loadVal;
          gapPend <= 1'b0;
        end
      end else if (gapPend) begin
        holdCnt <= loadVal;
        gapPend <= 1'b0;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end

    assign lowVec[g] = (holdCnt != '0);
  end

  assign upClkN  = ~lowVec[0];
  assign dnClkN  = ~lowVec[1];
  assign idxClkN = ~lowVec[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (strb.upStb) begin
      dirUp <= 1'b1;
    end else if (strb.dnStb) begin
      dirUp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strb.errSet) begin
      errFlag <= 1'b1;
    end else if (errClear) begin
      errFlag <= 1'b0;
    end
  end

  AST_DIR_FWD: assert property (@(posedge clk) disable iff (!rstN)
    strb.upStb |=> dirUp); // R4
  AST_DIR_REV: assert property (@(posedge clk) disable iff (!rstN)
    strb.dnStb |=> !dirUp); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClear) |=> errFlag); // R9
  AST_UP_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upStb && upClkN) |=> !upClkN); // R7
  AST_UP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upStb && !upClkN) |=> upClkN); // R8

endmodule

// File: rtl/quad_clock_converter.sv
module quad_clock_converter
  import qcc_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int WIDTH_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inA,
  input  logic               inB,
  input  logic               inIdx,
  input  logic [1:0]         modeSel,
  input  logic [WIDTH_W-1:0] pulseWidth,
  input  logic               errClear,
  output logic               upClkN,
  output logic               dnClkN,
  output logic               idxClkN,
  output logic               dirUp,
  output logic               errFlag
);
  localparam int N_IN = 3;

  logic [N_IN-1:0] rawVec;
  logic [N_IN-1:0] filtVec;
  qccStrobes_t     strb;

  assign rawVec = {inIdx, inB, inA};

  for (genvar c = 0; c < N_IN; c++) begin : gFilt
    qcc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawVec[c]),
      .filtOut(filtVec[c])
    );
  end

  qcc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fA     (filtVec[0]),
    .fB     (filtVec[1]),
    .fIdx   (filtVec[2]),
    .modeSel(modeSel),
    .strb   (strb)
  );

  qcc_datapath #(.WIDTH_W(WIDTH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pulseWidth(pulseWidth),
    .errClear  (errClear),
    .upClkN    (upClkN),
    .dnClkN    (dnClkN),
    .idxClkN   (idxClkN),
    .dirUp     (dirUp),
    .errFlag   (errFlag)
  );

endmodule

// File: tb/quad_clock_converter_bench.sv
module quad_clock_converter_bench;
  localparam int FILT_LEN = 3;
  localparam int WIDTH_W  = 8;
  localparam int N_VEC    = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inA = 1'b0, inB = 1'b0, inIdx = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic [WIDTH_W-1:0] pulseWidth = 8'd2;
  logic errClear = 1'b0;
  logic upClkN, dnClkN, idxClkN, dirUp, errFlag;

  int nChecks = 0;
  int nFail = 0;
  int upFalls = 0, dnFalls = 0, idxFalls = 0;
  logic prevUp = 1'b1, prevDn = 1'b1, prevIdx = 1'b1;

  always #10 clk = ~clk;

  quad_clock_converter #(.FILT_LEN(FILT_LEN), .WIDTH_W(WIDTH_W)) u_quad_clock_converter (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB), .inIdx(inIdx),
    .modeSel(modeSel), .pulseWidth(pulseWidth), .errClear(errClear),
    .upClkN(upClkN), .dnClkN(dnClkN), .idxClkN(idxClkN),
    .dirUp(dirUp), .errFlag(errFlag)
  );

  always @(negedge clk) begin
    if (prevUp && !upClkN) upFalls++;
    if (prevDn && !dnClkN) dnFalls++;
    if (prevIdx && !idxClkN) idxFalls++;
    prevUp = upClkN;
    prevDn = dnClkN;
    prevIdx = idxClkN;
  end

  // {mode[1:0], A, B, idx, expUp, expDn, expIdx, expDir, expErr}
  localparam logic [9:0] VEC [N_VEC] = '{
    10'b11_100_100_10, 10'b11_110_100_10, 10'b11_010_100_10, 10'b11_000_100_10,
    10'b11_010_010_00, 10'b11_110_010_00, 10'b00_100_000_00, 10'b01_000_010_00,
    10'b01_100_100_10, 10'b10_110_000_10, 10'b10_010_000_10, 10'b10_110_010_00,
    10'b10_100_000_00, 10'b10_000_000_00, 10'b10_100_100_10, 10'b11_101_000_10,
    10'b11_111_100_10, 10'b11_101_011_00, 10'b11_001_010_00, 10'b11_101_101_10,
    10'b11_000_010_00, 10'b11_100_100_10, 10'b11_010_000_11
  };

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int u0, d0, x0, lowCnt, firstLow;
    // R10: reset state
    waitCycles(4);
    chk("R10 upClkN in reset", upClkN, 1);
    chk("R10 dirUp in reset", dirUp, 1);
    rstN = 1'b1;
    waitCycles(12);
    chk("R10 no pulse after reset", upFalls + dnFalls + idxFalls, 0);
    chk("R10 idle outputs high", {upClkN, dnClkN, idxClkN}, 7);
    chk("R10 dirUp after reset", dirUp, 1);
    chk("R10 errFlag after reset", errFlag, 0);

    // R1 R2 R3 R4 R5 R9: vector table
    for (int v = 0; v < N_VEC; v++) begin
      u0 = upFalls; d0 = dnFalls; x0 = idxFalls;
      modeSel = VEC[v][9:8];
      inA = VEC[v][7]; inB = VEC[v][6]; inIdx = VEC[v][5];
      waitCycles(12);
      chk($sformatf("R1/R2/R3 up count vec %0d", v), upFalls - u0, int'(VEC[v][4]));
      chk($sformatf("R1/R2/R3 down count vec %0d", v), dnFalls - d0, int'(VEC[v][3]));
      chk($sformatf("R5 index count vec %0d", v), idxFalls - x0, int'(VEC[v][2]));
      chk($sformatf("R4 direction vec %0d", v), dirUp, int'(VEC[v][1]));
      chk($sformatf("R9 error flag vec %0d", v), errFlag, int'(VEC[v][0]));
    end

    // R9: clear
    errClear = 1'b1;
    waitCycles(1);
    errClear = 1'b0;
    waitCycles(2);
    chk("R9 errFlag cleared", errFlag, 0);

    // R6 R7: latency and width, A rise with B high -> reverse
    modeSel = 2'b11;
    pulseWidth = 8'd5;
    inA = 1'b1;
    lowCnt = 0; firstLow = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (!dnClkN) begin
        lowCnt++;
        if (firstLow == 0) firstLow = i;
      end
    end
    chk("R6 pulse start edge", firstLow, FILT_LEN + 3);
    chk("R7 pulse width 5", lowCnt, 5);
    chk("R4 direction after reverse", dirUp, 0);

    // R7: width zero treated as one, B fall with A high -> reverse
    pulseWidth = 8'd0;
    inB = 1'b0;
    lowCnt = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (!dnClkN) lowCnt++;
    end
    chk("R7 width zero gives one", lowCnt, 1);

    // R6: glitch shorter than the filter
    u0 = upFalls; d0 = dnFalls;
    inA = 1'b0;
    waitCycles(FILT_LEN - 1);
    inA = 1'b1;
    waitCycles(15);
    chk("R6 glitch rejected", (upFalls - u0) + (dnFalls - d0), 0);
    chk("R6 direction kept", dirUp, 0);

    // R8: restart inside a live pulse
    pulseWidth = 8'd8;
    u0 = upFalls;
    inB = 1'b1;
    lowCnt = 0;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (!upClkN) lowCnt++;
      if (i == 4) inA = 1'b0;
    end
    chk("R8 two separate pulses", upFalls - u0, 2);
    chk("R8 low cycles 4 plus 8", lowCnt, 12);

    // R10: reset with inputs held high
    pulseWidth = 8'd2;
    inA = 1'b1;
    waitCycles(12);
    chk("R4 reverse before reset", dirUp, 0);
    inIdx = 1'b1;
    waitCycles(4);
    rstN = 1'b0;
    waitCycles(4);
    rstN = 1'b1;
    u0 = upFalls; d0 = dnFalls; x0 = idxFalls;
    waitCycles(12);
    chk("R10 held inputs no pulse", (upFalls - u0) + (dnFalls - d0) + (idxFalls - x0), 0);
    chk("R10 dirUp after second reset", dirUp, 1);

    finishRun();
  end
endmodule